// File: doc/BRIEF.md
# Indirect Flash Read Sequencer

This block runs a programmed read from a serial flash device and keeps the returned data in a small internal word buffer. A single start request makes it send the opcode and then the start address, which is 3 or 4 bytes long. An optional 8-bit mode value and a number of dummy clocks come next. After that the block shifts in the requested number of data bytes. Each of the instruction, address and data phases can use one, two or four lanes, and the setting is made per phase.

Received bytes are packed little-endian into 32-bit words. The words are offered on a valid/ready stream. A word stays on the stream, unchanged, until the consumer accepts it. The consumer may hold ready low for as long as it likes. When that fills the buffer, the sequencer parks the serial clock low at the next word boundary and resumes once a slot frees up, so no byte is lost.

Software loads the read-instruction word, the address size, the mode value, the start address and the byte count, then writes the control port. The control port is a plain write strobe with a data byte. A status byte reports the busy and done flags, and a separate output gives the buffer fill level in words.

Top module: `flash_read_seq`

## Requirements
- R1: The read-instruction word holds the opcode in bits 7:0 and the instruction lane type in bits 9:8. The opcode goes out MSB first. Lane types are: 1 is dual on io[1:0], 2 is quad on io[3:0], and 0 or 3 is single on io[0]. On multi-lane transfers the higher lane carries the higher bit.
- R2: The address goes out MSB first on the lane type in bits 13:12. It is 4 bytes when the address-size input is 3; any other value gives the low 3 bytes.
- R3: When bit 20 of the instruction word is set, the mode byte goes out MSB first on io[0] over 8 serial clocks, right after the address.
- R4: The number in bits 28:24 sets the dummy clocks, which follow the mode byte, or the address if there is no mode byte. The outputs are not driven (io_oe = 0) during the dummy clocks or the data phase. A complete read lasts exactly as many serial clocks as all the phases add up to.
- R5: Data is sampled on each rising serial clock, MSB first, using the lane type in bits 17:16. Single lane reads io[1], dual reads io[1:0] and quad reads io[3:0]. Exactly the programmed byte count is received.
- R6: Byte k of the read is placed in bits 8*(k mod 4)+7 down to 8*(k mod 4) of word k/4. A final word that is only partly filled is pushed with its upper bytes zero.
- R7: While rd_valid is high and rd_ready is low, rd_valid stays high and rd_data holds its value.
- R8: fill_level counts the buffered words and never goes above the buffer depth (4 by default).
- R9: If the buffer is full when a new word is about to start, the serial clock is held low with no further edges until a word is popped.
- R10: Writing control bit 0 while idle starts a read. Status bit 2 (busy) and the active-low chip select stay asserted from the next cycle until the last byte is received. The serial clock idles low.
- R11: Status bit 5 (done) is set when the last byte is received. Writing 1 to control bit 5 clears it.
- R12: Writing control bit 1 stops a read on the next cycle. Chip select is released, the buffer is emptied, busy drops, and done is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the serial clock runs at half its rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_rd_instr | input | 32 | Read-instruction word (opcode, lane types, mode enable, dummy count) |
| cfg_addr_size | input | 2 | Address bytes minus one (3 selects 4 bytes) |
| cfg_mode_byte | input | 8 | Mode value sent after the address |
| cfg_flash_addr | input | 32 | Start flash address |
| cfg_xfer_bytes | input | 16 | Number of bytes to read |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 8 | Control write data: bit0 start, bit1 cancel, bit5 clear done |
| ctl_status | output | 8 | Status: bit2 busy, bit5 done, other bits zero |
| fill_level | output | 16 | Buffered words |
| rd_valid | output | 1 | Stream word available |
| rd_ready | input | 1 | Stream consumer accepts the word |
| rd_data | output | 32 | Stream word |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| io_out | output | 4 | Serial data out per lane |
| io_oe | output | 4 | Output enable per lane |
| io_in | input | 4 | Serial data in per lane |

## Verification
A wrong phase count or a wrong lane width shifts every later bit. This shows up right away in the captured opcode or address, or as a total serial clock count that is off by the first few clocks of the read. A wrong byte index in the packer puts bytes in the wrong lanes of the first word popped, or gives a final word with data where the zero padding should be. A bad buffer count or a bad stall decision appears within one word time: the fill level goes past the depth, or serial clock edges appear while the buffer is full. A missed cancel or completion shows up one cycle after the control write, as chip select still low or a stale busy or done flag.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_CMD, PH_ADDR, PH_MODE, PH_DUMMY, PH_DATA
  } phase_e;

  // read-instruction word field positions
  localparam int OPC_LSB     = 0;
  localparam int ILANE_LSB   = 8;
  localparam int ALANE_LSB   = 12;
  localparam int DLANE_LSB   = 16;
  localparam int MODE_EN_BIT = 20;
  localparam int DUMMY_LSB   = 24;

  // control / status bit positions
  localparam int CTL_START  = 0;
  localparam int CTL_CANCEL = 1;
  localparam int CTL_BUSY   = 2;
  localparam int CTL_DONE   = 5;

  // bits moved per serial clock for a lane type
  function automatic logic [2:0] lane_bits(input logic [1:0] t);
    case (t)
      2'd1:    lane_bits = 3'd2;
      2'd2:    lane_bits = 3'd4;
      default: lane_bits = 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/fsr_fifo.sv
module fsr_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data,
  output logic [LW-1:0]    level,
  output logic             full
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [LW-1:0]    cnt;
  logic             do_push, do_pop;

  assign full      = (cnt == LW'(DEPTH));
  assign out_valid = (cnt != '0);
  assign out_data  = mem[rp];
  assign level     = cnt;
  assign do_push   = push && !full && !flush;
  assign do_pop    = out_valid && out_ready && !flush;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/fsr_packer.sv
module fsr_packer #(
  parameter int WORD_BYTES = 4,
  localparam int WW = WORD_BYTES * 8,
  localparam int IW = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          byte_valid,
  input  logic [7:0]    byte_data,
  input  logic          byte_last,
  output logic          word_valid,
  output logic [WW-1:0] word_data,
  output logic          word_start
);
  logic [IW-1:0] idx;
  logic [WW-1:0] acc, merged;

  // little-endian placement: byte k of a word lands at bits 8k+7:8k
  assign merged     = acc | (WW'(byte_data) << {idx, 3'b000});
  assign word_valid = byte_valid && ((idx == IW'(WORD_BYTES - 1)) || byte_last);
  assign word_data  = merged;
  assign word_start = (idx == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0; idx <= '0;
    end else if (clear) begin
      acc <= '0; idx <= '0;
    end else if (byte_valid) begin
      if (word_valid) begin
        acc <= '0; idx <= '0;
      end else begin
        acc <= merged; idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fsr_engine.sv
module fsr_engine
  import fsr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cancel,
  input  logic [7:0]       opcode,
  input  logic [1:0]       ilane,
  input  logic [1:0]       alane,
  input  logic [1:0]       dlane,
  input  logic             mode_en,
  input  logic [4:0]       dummy_clks,
  input  logic [1:0]       addr_size,
  input  logic [7:0]       mode_byte,
  input  logic [31:0]      flash_addr,
  input  logic [CNT_W-1:0] xfer_bytes,
  input  logic             word_start,
  input  logic             fifo_full,
  input  logic [3:0]       io_in,
  output logic             sclk,
  output logic             cs_n,
  output logic [3:0]       io_out,
  output logic [3:0]       io_oe,
  output logic             byte_valid,
  output logic [7:0]       byte_data,
  output logic             byte_last,
  output logic             busy,
  output logic             finish
);
  phase_e           st, end_st;
  logic             sclk_q, cs_q;
  logic [5:0]       bits_left, end_bits;
  logic [31:0]      tx_sr, end_tx;
  logic [7:0]       rx_sr, rx_nx;
  logic [CNT_W-1:0] left;
  logic [1:0]       il_q, al_q, dl_q;
  logic             me_q, four_q;
  logic [4:0]       dum_q;
  logic [7:0]       mode_q;
  logic [31:0]      addr_q;
  logic [2:0]       w;
  logic             stall, drive;

  always_comb begin
    case (st)
      PH_CMD:  w = lane_bits(il_q);
      PH_ADDR: w = lane_bits(al_q);
      PH_DATA: w = lane_bits(dl_q);
      default: w = 3'd1;
    endcase
  end

  // what follows the current header phase
  always_comb begin
    end_st = PH_DATA; end_bits = 6'd8; end_tx = tx_sr;
    case (st)
      PH_CMD: begin
        end_st   = PH_ADDR;
        end_bits = four_q ? 6'd32 : 6'd24;
        end_tx   = four_q ? addr_q : {addr_q[23:0], 8'h00};
      end
      PH_ADDR: begin
        if (me_q) begin
          end_st = PH_MODE; end_bits = 6'd8; end_tx = {mode_q, 24'h0};
        end else if (dum_q != '0) begin
          end_st = PH_DUMMY; end_bits = {1'b0, dum_q};
        end
      end
      PH_MODE: begin
        if (dum_q != '0) begin
          end_st = PH_DUMMY; end_bits = {1'b0, dum_q};
        end
      end
      default: ;
    endcase
  end

  always_comb begin
    case (w)
      3'd2:    rx_nx = {rx_sr[5:0], io_in[1:0]};
      3'd4:    rx_nx = {rx_sr[3:0], io_in[3:0]};
      default: rx_nx = {rx_sr[6:0], io_in[1]};
    endcase
  end

  assign stall = (st == PH_DATA) && (bits_left == 6'd8) && word_start && fifo_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= PH_IDLE; sclk_q <= 1'b0; cs_q <= 1'b1; bits_left <= '0;
      tx_sr <= '0; rx_sr <= '0; left <= '0;
      il_q <= '0; al_q <= '0; dl_q <= '0; me_q <= 1'b0; four_q <= 1'b0;
      dum_q <= '0; mode_q <= '0; addr_q <= '0;
    end else if (cancel) begin
      st <= PH_IDLE; sclk_q <= 1'b0; cs_q <= 1'b1;
    end else if (st == PH_IDLE) begin
      if (start && xfer_bytes != '0) begin
        il_q <= ilane; al_q <= alane; dl_q <= dlane; me_q <= mode_en;
        dum_q <= dummy_clks; mode_q <= mode_byte; addr_q <= flash_addr;
        four_q <= (addr_size == 2'd3);
        left <= xfer_bytes;
        st <= PH_CMD; cs_q <= 1'b0; sclk_q <= 1'b0;
        bits_left <= 6'd8; tx_sr <= {opcode, 24'h0};
      end
    end else if (!sclk_q) begin
      // rising serial edge: sample and count
      if (!stall) begin
        sclk_q    <= 1'b1;
        bits_left <= bits_left - {3'b000, w};
        if (st == PH_DATA) rx_sr <= rx_nx;
      end
    end else begin
      // falling serial edge: shift out or change phase
      sclk_q <= 1'b0;
      if (bits_left != '0) begin
        tx_sr <= tx_sr << w;
      end else if (st == PH_DATA) begin
        if (left == CNT_W'(1)) begin
          st <= PH_IDLE; cs_q <= 1'b1;
        end else begin
          left <= left - 1'b1; bits_left <= 6'd8;
        end
      end else begin
        st <= end_st; bits_left <= end_bits; tx_sr <= end_tx;
      end
    end
  end

  assign drive = (st == PH_CMD) || (st == PH_ADDR) || (st == PH_MODE);

  always_comb begin
    io_oe = 4'b0000; io_out = 4'b0000;
    if (drive) begin
      case (w)
        3'd2:    begin io_oe = 4'b0011; io_out = {2'b00, tx_sr[31:30]}; end
        3'd4:    begin io_oe = 4'b1111; io_out = tx_sr[31:28]; end
        default: begin io_oe = 4'b0001; io_out = {3'b000, tx_sr[31]}; end
      endcase
    end
  end

  assign sclk       = sclk_q;
  assign cs_n       = cs_q;
  assign busy       = (st != PH_IDLE);
  assign byte_valid = (st == PH_DATA) && sclk_q && (bits_left == '0) && !cancel;
  assign byte_data  = rx_sr;
  assign byte_last  = (left == CNT_W'(1));
  assign finish     = (byte_valid && byte_last) ||
                      (start && !cancel && (st == PH_IDLE) && (xfer_bytes == '0));
endmodule

// File: rtl/flash_read_seq.sv
module flash_read_seq
  import fsr_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int CNT_W      = 16,
  localparam int LW        = ((FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      cfg_rd_instr,
  input  logic [1:0]       cfg_addr_size,
  input  logic [7:0]       cfg_mode_byte,
  input  logic [31:0]      cfg_flash_addr,
  input  logic [CNT_W-1:0] cfg_xfer_bytes,
  input  logic             ctl_wr,
  input  logic [7:0]       ctl_wdata,
  output logic [7:0]       ctl_status,
  output logic [15:0]      fill_level,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [31:0]      rd_data,
  output logic             sclk,
  output logic             cs_n,
  output logic [3:0]       io_out,
  output logic [3:0]       io_oe,
  input  logic [3:0]       io_in
);
  logic          start_req, cancel_req, clr_done;
  logic          busy, finish_w, done_q;
  logic          byte_valid, byte_last, word_valid, word_start, fifo_full;
  logic [7:0]    byte_data;
  logic [31:0]   word_data;
  logic [LW-1:0] level;
  logic          unused_rsvd;

  assign cancel_req = ctl_wr && ctl_wdata[CTL_CANCEL];
  assign start_req  = ctl_wr && ctl_wdata[CTL_START] && !ctl_wdata[CTL_CANCEL];
  assign clr_done   = ctl_wr && ctl_wdata[CTL_DONE];
  assign unused_rsvd = ^{cfg_rd_instr[31:29], cfg_rd_instr[23:21], cfg_rd_instr[19:18],
                         cfg_rd_instr[15:14], cfg_rd_instr[11:10]};

  fsr_engine #(.CNT_W(CNT_W)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_req),
    .cancel     (cancel_req),
    .opcode     (cfg_rd_instr[OPC_LSB +: 8]),
    .ilane      (cfg_rd_instr[ILANE_LSB +: 2]),
    .alane      (cfg_rd_instr[ALANE_LSB +: 2]),
    .dlane      (cfg_rd_instr[DLANE_LSB +: 2]),
    .mode_en    (cfg_rd_instr[MODE_EN_BIT]),
    .dummy_clks (cfg_rd_instr[DUMMY_LSB +: 5]),
    .addr_size  (cfg_addr_size),
    .mode_byte  (cfg_mode_byte),
    .flash_addr (cfg_flash_addr),
    .xfer_bytes (cfg_xfer_bytes),
    .word_start (word_start),
    .fifo_full  (fifo_full),
    .io_in      (io_in),
    .sclk       (sclk),
    .cs_n       (cs_n),
    .io_out     (io_out),
    .io_oe      (io_oe),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .byte_last  (byte_last),
    .busy       (busy),
    .finish     (finish_w)
  );

  fsr_packer #(.WORD_BYTES(4)) u_pack (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (cancel_req),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .byte_last  (byte_last),
    .word_valid (word_valid),
    .word_data  (word_data),
    .word_start (word_start)
  );

  fsr_fifo #(.WIDTH(32), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (cancel_req),
    .push      (word_valid),
    .push_data (word_data),
    .out_ready (rd_ready),
    .out_valid (rd_valid),
    .out_data  (rd_data),
    .level     (level),
    .full      (fifo_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        done_q <= 1'b0;
    else if (finish_w) done_q <= 1'b1;
    else if (clr_done) done_q <= 1'b0;
  end

  always_comb begin
    ctl_status = 8'h00;
    ctl_status[CTL_BUSY] = busy;
    ctl_status[CTL_DONE] = done_q;
  end

  assign fill_level = 16'(level);
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker #(
  parameter int DEPTH = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_wr,
  input logic [7:0]  ctl_wdata,
  input logic [7:0]  ctl_status,
  input logic [15:0] fill_level,
  input logic        rd_valid,
  input logic        rd_ready,
  input logic [31:0] rd_data,
  input logic        sclk,
  input logic        cs_n,
  input logic        fin
);
  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= 16'(DEPTH));

  // R10
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_status[2] |-> (cs_n && !sclk));

  // R11
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> (ctl_status[5] && !ctl_status[2]));

  // R11
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_wdata[5] && !fin) |=> !ctl_status[5]);

  // R12
  cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_wdata[1] && !ctl_wdata[5]) |=>
      (!ctl_status[2] && cs_n && fill_level == 16'd0 && $stable(ctl_status[5])));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !(ctl_wr && ctl_wdata[1])) |=> (rd_valid && $stable(rd_data)));
endmodule

bind flash_read_seq fsr_checker #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctl_wr     (ctl_wr),
  .ctl_wdata  (ctl_wdata),
  .ctl_status (ctl_status),
  .fill_level (fill_level),
  .rd_valid   (rd_valid),
  .rd_ready   (rd_ready),
  .rd_data    (rd_data),
  .sclk       (sclk),
  .cs_n       (cs_n),
  .fin        (finish_w)
);

// File: tb/flash_read_seq_tb.sv
module flash_read_seq_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic [31:0] cfg_rd_instr, cfg_flash_addr;
  logic [1:0]  cfg_addr_size;
  logic [7:0]  cfg_mode_byte, ctl_wdata, ctl_status;
  logic [15:0] cfg_xfer_bytes, fill_level;
  logic        ctl_wr, rd_valid, rd_ready, sclk, cs_n;
  logic [31:0] rd_data;
  logic [3:0]  io_out, io_oe, io_in;

  flash_read_seq u_dut (.*);

  int errors = 0, checks = 0;
  // expected configuration of the current read
  int e_wi, e_wa, e_wd, e_nb, e_dum, e_n, n_cmd, n_adr, n_mode, pre_rises;
  logic [31:0] e_addr;

  // flash model state
  int          rise_cnt = 0;
  logic [7:0]  cap_op, cap_mode;
  logic [31:0] cap_addr;
  logic [31:0] got [64];
  int          got_n = 0;

  function automatic logic [7:0] pat(input logic [31:0] a);
    pat = (a[7:0] * 8'd29) ^ 8'h6B;
  endfunction

  function automatic logic [3:0] lanes(input logic [3:0] v, input int w);
    if (w == 1) lanes = {3'b0, v[0]};
    else if (w == 2) lanes = {2'b0, v[1:0]};
    else lanes = v;
  endfunction

  function automatic logic [3:0] nib(input int k, input int p, input int w, input logic [31:0] a);
    int r, bp, off;
    logic [7:0] b, v;
    r = k - p;
    if (r < 0) return 4'h0;
    bp = r * w; off = bp % 8;
    b = pat(a + 32'(bp / 8));
    v = b >> (8 - off - w);
    if (w == 1) return {2'b0, v[0], 1'b0};
    if (w == 2) return {2'b0, v[1:0]};
    return v[3:0];
  endfunction

  always_comb io_in = nib(rise_cnt, pre_rises, e_wd, e_addr);

  always @(posedge sclk or negedge cs_n) begin
    if (!sclk) begin
      rise_cnt = 0; cap_op = 0; cap_addr = 0; cap_mode = 0;
    end else begin
      if (rise_cnt < n_cmd) cap_op = (cap_op << e_wi) | 8'(lanes(io_out, e_wi));
      else if (rise_cnt < n_cmd + n_adr) cap_addr = (cap_addr << e_wa) | 32'(lanes(io_out, e_wa));
      else if (rise_cnt < n_cmd + n_adr + n_mode) cap_mode = {cap_mode[6:0], io_out[0]};
      rise_cnt = rise_cnt + 1;
    end
  end

  always @(negedge clk) begin
    if (rd_valid && rd_ready) begin
      got[got_n % 64] = rd_data;
      got_n = got_n + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic int lw(input int t);
    lw = (t == 1) ? 2 : (t == 2) ? 4 : 1;
  endfunction

  task automatic setup(input int wi_t, input int wa_t, input int wd_t, input int nb, input bit me,
                       input int dum, input int n, input logic [31:0] a, input logic [7:0] op,
                       input logic [7:0] mv);
    cfg_rd_instr = {3'b0, 5'(dum), 3'b0, me, 2'b0, 2'(wd_t), 2'b0, 2'(wa_t), 2'b0, 2'(wi_t), op};
    cfg_addr_size = (nb == 4) ? 2'd3 : 2'd2;
    cfg_mode_byte = mv; cfg_flash_addr = a; cfg_xfer_bytes = 16'(n);
    e_wi = lw(wi_t); e_wa = lw(wa_t); e_wd = lw(wd_t); e_nb = nb; e_dum = dum; e_n = n;
    e_addr = a;
    n_cmd = 8 / e_wi; n_adr = 8 * nb / e_wa; n_mode = me ? 8 : 0;
    pre_rises = n_cmd + n_adr + n_mode + dum;
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 1'b0; ctl_wdata = 8'h00;
  endtask

  task automatic wait_idle();
    for (int c = 0; c < 20000 && ctl_status[2]; c++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_words(input int base);
    for (int m = 0; m < (e_n + 3) / 4; m++) begin
      logic [31:0] exp;
      exp = 0;
      for (int b = 0; b < 4; b++)
        if (4 * m + b < e_n) exp[8*b +: 8] = pat(e_addr + 32'(4 * m + b));
      chk(got[(base + m) % 64] == exp, "R5/R6 word", got[(base + m) % 64], exp);
    end
    chk(got_n - base == (e_n + 3) / 4, "R5 word count", 32'(got_n - base), 32'((e_n + 3) / 4));
  endtask

  task automatic run(input int wi_t, input int wa_t, input int wd_t, input int nb, input bit me,
                     input int dum, input int n, input logic [31:0] a, input logic [7:0] op,
                     input logic [7:0] mv);
    int base;
    setup(wi_t, wa_t, wd_t, nb, me, dum, n, a, op, mv);
    base = got_n;
    wr(8'h01);
    chk(ctl_status[2] && !cs_n, "R10 busy and cs after start", {ctl_status, 23'b0, cs_n}, 32'h0400_0000);
    wait_idle();
    chk(!ctl_status[2] && cs_n, "R10 idle after read", {24'b0, ctl_status}, 32'h20);
    chk(ctl_status[5], "R11 done set", 32'(ctl_status[5]), 32'd1);
    chk(cap_op == op, "R1 opcode", 32'(cap_op), 32'(op));
    chk(cap_addr == ((nb == 4) ? a : {8'h0, a[23:0]}), "R2 address", cap_addr,
        (nb == 4) ? a : {8'h0, a[23:0]});
    if (me) chk(cap_mode == mv, "R3 mode byte", 32'(cap_mode), 32'(mv));
    chk(rise_cnt == pre_rises + n * 8 / e_wd, "R4 serial clock count", 32'(rise_cnt),
        32'(pre_rises + n * 8 / e_wd));
    check_words(base);
    wr(8'h20);
    chk(!ctl_status[5], "R11 done cleared by write", 32'(ctl_status[5]), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R10 watchdog: actual=hung expected=finished");
    summary();
  end

  initial begin
    int i;
    rst_n = 1'b0; ctl_wr = 1'b0; ctl_wdata = 0; rd_ready = 1'b1;
    setup(0, 0, 0, 3, 0, 0, 1, 32'h0, 8'h03, 8'h00);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && !sclk && ctl_status == 8'h00 && fill_level == 0 && !rd_valid && io_oe == 0,
        "R10 reset state", {ctl_status, fill_level, 6'b0, cs_n, sclk}, 32'h0000_0002);

    // near-exhaustive sweep over lane types, address size, mode byte and length
    i = 0;
    for (int wd = 0; wd < 3; wd++)
      for (int nb = 3; nb <= 4; nb++)
        for (int me = 0; me < 2; me++)
          foreach (lens[k]) begin
            run(i % 3, (i / 3) % 3, wd, nb, me[0], (i * 7) % 12, lens[k],
                32'h00A1_0000 + 32'(i) * 32'h0001_0313, 8'(8'h0B + i), 8'(8'hA0 ^ i));
            i++;
          end

    // R9 / R8 / R7: consumer stalls, buffer fills, serial clock parks low
    begin
      int base, r0;
      logic [31:0] d0;
      setup(0, 0, 2, 3, 0, 0, 24, 32'h0000_4410, 8'hEB, 8'h00);
      rd_ready = 1'b0; base = got_n;
      wr(8'h01);
      repeat (400) @(negedge clk);
      chk(fill_level == 16'd4, "R8 level at depth", 32'(fill_level), 32'd4);
      chk(ctl_status[2] && !cs_n, "R9 still busy while stalled", 32'(ctl_status), 32'h04);
      r0 = rise_cnt; d0 = rd_data;
      repeat (30) @(negedge clk);
      chk(rise_cnt == r0 && !sclk, "R9 no serial edges while full", 32'(rise_cnt), 32'(r0));
      chk(rd_valid && rd_data == d0, "R7 word held while not ready", rd_data, d0);
      chk(d0 == {pat(32'h4413), pat(32'h4412), pat(32'h4411), pat(32'h4410)},
          "R6 first word order", d0, {pat(32'h4413), pat(32'h4412), pat(32'h4411), pat(32'h4410)});
      rd_ready = 1'b1;
      wait_idle();
      check_words(base);
      chk(rise_cnt == pre_rises + 48, "R9 resumes to full length", 32'(rise_cnt), 32'(pre_rises + 48));
      wr(8'h20);
    end

    // R12: cancel in the middle of a read
    begin
      setup(0, 0, 0, 4, 1, 3, 40, 32'h0102_0304, 8'h0C, 8'h5A);
      rd_ready = 1'b0;
      wr(8'h01);
      repeat (250) @(negedge clk);
      chk(fill_level != 0 && ctl_status[2], "R12 read under way before cancel", 32'(fill_level), 32'd1);
      wr(8'h02);
      chk(!ctl_status[2] && cs_n && !sclk, "R12 stopped", {24'b0, ctl_status}, 32'h0);
      chk(fill_level == 0 && !rd_valid, "R12 buffer emptied", 32'(fill_level), 32'd0);
      chk(!ctl_status[5], "R12 done not set", 32'(ctl_status[5]), 32'd0);
      repeat (20) @(negedge clk);
      chk(cs_n && fill_level == 0, "R12 stays idle", 32'(fill_level), 32'd0);
      rd_ready = 1'b1;
    end

    // recovery after cancel, quad everywhere with 4-byte address
    run(2, 2, 2, 4, 1, 6, 6, 32'hCAFE_0123, 8'hEC, 8'hF0);
    summary();
  end

  int lens [7] = '{1, 2, 3, 4, 5, 8, 9};
endmodule